// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sequences trap entry and trap return for a 32-bit core with a system-control coprocessor. When the pipeline raises an exception request, it carries a 5-bit cause code and a flag that says whether the faulting instruction sat in a branch delay slot. The block then updates the saved return address, the cause register and the status register, and produces the handler address. When a return-from-exception is requested, the block picks the return address from the normal save register or from the error save register. It clears the matching status level, splits bit 0 of the address off as the instruction-set mode, and pulses a clear of the load-linked reservation.

Both request inputs are valid/ready streams. They share one ready, which is high whenever the redirect output slot is empty or is being drained in the same cycle. The redirect output (new PC and ISA mode) is a valid/ready stream held in a register. While `redir_ready` is low, the redirect stays on the output unchanged and no new request is taken. A request presented while its ready is low is not consumed and has no effect. A plain load port lets the core's move-to-coprocessor path write the status, cause, save and base registers. The current register values are driven out as plain outputs.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, status reads 0x0040_0000 (only the boot-vector bit 22 set), cause reads 0, the handler base reads 0x8000_0000, and `redir_valid` and `ll_clear` are 0.
- R2: An exception taken while status bit 1 (EXL) is 0 stores `cur_pc | cur_isa` into the save register, and sets cause bit 31 (BD) to `exc_in_slot`.
- R3: An exception taken while EXL is already 1 leaves the save register and cause bit 31 unchanged.
- R4: Every exception entry replaces cause bits 6:2 with `exc_code`, and keeps cause bit 23 (IV).
- R5: Every exception entry sets EXL (status bit 1), clears ERL (status bit 2), and presents `redir_isa` = 0.
- R6: The handler base is 0xBFC0_0200 when status bit 22 (BEV) is 1, and the loaded base register otherwise. Only bits 31:12 of the base register are writable; bits 11:0 read as 0. The general offset is 0x180.
- R7: When EXL was 0 at entry, codes 2 and 3 (translation miss on load or store) use offset 0x000.
- R8: When EXL was 0 at entry, code 0 (interrupt) with cause IV = 1 uses offset 0x200.
- R9: A return with ERL = 1 clears ERL and targets the error save register. Otherwise it clears EXL and targets the save register.
- R10: A return presents bit 0 of the target on `redir_isa` and the target with bit 0 cleared on `redir_pc`. `ll_clear` is high for exactly the one cycle in which that redirect first appears.
- R11: An exception request and a return request valid in the same cycle: the exception is taken and the return is dropped, with no `ll_clear` and no status change from the return.
- R12: While `redir_valid` is 1 and `redir_ready` is 0, the redirect stays stable, both readies are 0, and requests have no effect.
- R13: Load port selects are 0 status, 1 cause (only bit 23 writable), 2 save register, 3 error save register, 4 base. A load in a cycle that takes an exception or a return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_isa | input | 1 | Current compressed-ISA mode bit |
| exc_valid | input | 1 | Exception request valid |
| exc_ready | output | 1 | Exception request ready |
| exc_code | input | 5 | Exception cause code |
| exc_in_slot | input | 1 | Faulting instruction is in a delay slot |
| eret_valid | input | 1 | Return request valid |
| eret_ready | output | 1 | Return request ready |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register load target |
| ld_data | input | 32 | Register load value |
| redir_valid | output | 1 | Redirect valid |
| redir_ready | input | 1 | Redirect accepted by the fetch stage |
| redir_pc | output | 32 | New program counter |
| redir_isa | output | 1 | New ISA mode |
| ll_clear | output | 1 | Load-linked reservation clear pulse |
| status_q | output | 32 | Status register |
| cause_q | output | 32 | Cause register |
| epc_q | output | 32 | Save register |
| errorepc_q | output | 32 | Error save register |
| ebase_q | output | 32 | Handler base register |

## Verification
Every result of an accepted request is due one clock edge after acceptance. This covers the redirect, `ll_clear`, and the status, cause and save register updates. A load is visible one edge after its strobe. The bench drives all inputs on the falling edge and reads the results on the next falling edge, so exactly one rising edge lies between stimulus and check. For the back-pressure case it checks again after each further edge, to see that the redirect is held and then released.

// File: rtl/trap_pkg.sv
package trap_pkg;
  // status bit positions
  localparam int ST_IE  = 0;
  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int ST_BEV = 22;
  // cause bit positions
  localparam int CA_CODE_LO = 2;
  localparam int CA_CODE_HI = 6;
  localparam int CA_IV  = 23;
  localparam int CA_BD  = 31;

  localparam logic [31:0] STATUS_RST = 32'h0040_0000;
  localparam logic [31:0] EBASE_RST  = 32'h8000_0000;
  localparam logic [31:0] EBASE_MASK = 32'hFFFF_F000;
  localparam logic [31:0] BOOT_BASE  = 32'hBFC0_0200;

  localparam logic [31:0] OFS_REFILL = 32'h0000_0000;
  localparam logic [31:0] OFS_COMMON = 32'h0000_0180;
  localparam logic [31:0] OFS_IRQ    = 32'h0000_0200;

  localparam logic [4:0] CODE_INT  = 5'd0;
  localparam logic [4:0] CODE_TLBL = 5'd2;
  localparam logic [4:0] CODE_TLBS = 5'd3;

  typedef enum logic [2:0] {
    LD_STATUS = 3'd0,
    LD_CAUSE  = 3'd1,
    LD_EPC    = 3'd2,
    LD_ERREPC = 3'd3,
    LD_EBASE  = 3'd4
  } ld_sel_e;
endpackage

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [XLEN-1:0]   status,
  input  logic [XLEN-1:0]   cause,
  input  logic [XLEN-1:0]   ebase,
  input  logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   vector
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] ofs;
  logic            first_level;
  logic            is_refill;
  logic            is_vec_irq;

  always_comb begin
    first_level = !status[ST_EXL];
    is_refill   = (code == CODE_W'(CODE_TLBL)) || (code == CODE_W'(CODE_TLBS));
    is_vec_irq  = (code == CODE_W'(CODE_INT)) && cause[CA_IV];
    base        = status[ST_BEV] ? XLEN'(BOOT_BASE) : ebase;
    if (first_level && is_refill)       ofs = XLEN'(OFS_REFILL);
    else if (first_level && is_vec_irq) ofs = XLEN'(OFS_IRQ);
    else                                ofs = XLEN'(OFS_COMMON);
    vector = base + ofs;
  end
endmodule

// File: rtl/trap_return_sel.sv
module trap_return_sel
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] errorepc,
  output logic [XLEN-1:0] ret_pc,
  output logic            ret_isa,
  output logic            from_err
);
  logic [XLEN-1:0] target;

  always_comb begin
    from_err = status[ST_ERL];
    target   = from_err ? errorepc : epc;
    ret_isa  = target[0];
    ret_pc   = {target[XLEN-1:1], 1'b0};
  end
endmodule

// File: rtl/trap_state_regs.sv
module trap_state_regs
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_exc,
  input  logic              take_ret,
  input  logic              ret_from_err,
  input  logic [CODE_W-1:0] code,
  input  logic              in_slot,
  input  logic [XLEN-1:0]   pc,
  input  logic              isa,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [XLEN-1:0]   ld_data,
  output logic [XLEN-1:0]   status_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   errorepc_q,
  output logic [XLEN-1:0]   ebase_q
);
  logic            ld_ok;
  logic [XLEN-1:0] status_d, cause_d, epc_d, errorepc_d, ebase_d;

  assign ld_ok = ld_en && !take_exc && !take_ret;

  always_comb begin
    status_d   = status_q;
    cause_d    = cause_q;
    epc_d      = epc_q;
    errorepc_d = errorepc_q;
    ebase_d    = ebase_q;
    if (take_exc) begin
      if (!status_q[ST_EXL]) begin
        epc_d        = pc | XLEN'(isa);
        cause_d[CA_BD] = in_slot;
      end
      cause_d[CA_CODE_HI:CA_CODE_LO] = code;
      status_d[ST_EXL] = 1'b1;
      status_d[ST_ERL] = 1'b0;
    end else if (take_ret) begin
      if (ret_from_err) status_d[ST_ERL] = 1'b0;
      else              status_d[ST_EXL] = 1'b0;
    end else if (ld_ok) begin
      case (ld_sel_e'(ld_sel))
        LD_STATUS: status_d   = ld_data;
        LD_CAUSE:  cause_d[CA_IV] = ld_data[CA_IV];
        LD_EPC:    epc_d      = ld_data;
        LD_ERREPC: errorepc_d = ld_data;
        LD_EBASE:  ebase_d    = ld_data & XLEN'(EBASE_MASK);
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= XLEN'(STATUS_RST);
      cause_q    <= '0;
      epc_q      <= '0;
      errorepc_q <= '0;
      ebase_q    <= XLEN'(EBASE_RST);
    end else begin
      status_q   <= status_d;
      cause_q    <= cause_d;
      epc_q      <= epc_d;
      errorepc_q <= errorepc_d;
      ebase_q    <= ebase_d;
    end
  end

  // R5: entry leaves EXL set and ERL clear
  p_entry_levels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> (status_q[ST_EXL] && !status_q[ST_ERL]));
  // R3: nested entry keeps save register and BD
  p_nested_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && status_q[ST_EXL]) |=>
      (epc_q == $past(epc_q) && cause_q[CA_BD] == $past(cause_q[CA_BD])));
  // R4: code field follows the request
  p_code_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> cause_q[CA_CODE_HI:CA_CODE_LO] == $past(code));
  // R9: return from error level only touches ERL
  p_ret_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ret && ret_from_err) |=>
      (!status_q[ST_ERL] && status_q[ST_EXL] == $past(status_q[ST_EXL])));
  // R6: low base bits stay zero
  p_ebase_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ebase_q[11:0] == 12'h000);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              cur_isa,
  input  logic              exc_valid,
  output logic              exc_ready,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_in_slot,
  input  logic              eret_valid,
  output logic              eret_ready,
  input  logic              ld_en,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [XLEN-1:0]   ld_data,
  output logic              redir_valid,
  input  logic              redir_ready,
  output logic [XLEN-1:0]   redir_pc,
  output logic              redir_isa,
  output logic              ll_clear,
  output logic [XLEN-1:0]   status_q,
  output logic [XLEN-1:0]   cause_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   errorepc_q,
  output logic [XLEN-1:0]   ebase_q
);
  logic            slot_free;
  logic            take_exc;
  logic            take_ret;
  logic [XLEN-1:0] vec_pc;
  logic [XLEN-1:0] ret_pc;
  logic            ret_isa;
  logic            ret_from_err;

  assign slot_free  = !redir_valid || redir_ready;
  assign exc_ready  = slot_free;
  assign eret_ready = slot_free;
  assign take_exc   = exc_valid && slot_free;
  assign take_ret   = eret_valid && slot_free && !exc_valid;

  trap_state_regs #(.XLEN(XLEN), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_exc    (take_exc),
    .take_ret    (take_ret),
    .ret_from_err(ret_from_err),
    .code        (exc_code),
    .in_slot     (exc_in_slot),
    .pc          (cur_pc),
    .isa         (cur_isa),
    .ld_en       (ld_en),
    .ld_sel      (ld_sel),
    .ld_data     (ld_data),
    .status_q    (status_q),
    .cause_q     (cause_q),
    .epc_q       (epc_q),
    .errorepc_q  (errorepc_q),
    .ebase_q     (ebase_q)
  );

  trap_vector_gen #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .status(status_q),
    .cause (cause_q),
    .ebase (ebase_q),
    .code  (exc_code),
    .vector(vec_pc)
  );

  trap_return_sel #(.XLEN(XLEN)) u_ret (
    .status  (status_q),
    .epc     (epc_q),
    .errorepc(errorepc_q),
    .ret_pc  (ret_pc),
    .ret_isa (ret_isa),
    .from_err(ret_from_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      redir_isa   <= 1'b0;
      ll_clear    <= 1'b0;
    end else begin
      ll_clear <= take_ret;
      if (take_exc) begin
        redir_valid <= 1'b1;
        redir_pc    <= vec_pc;
        redir_isa   <= 1'b0;
      end else if (take_ret) begin
        redir_valid <= 1'b1;
        redir_pc    <= ret_pc;
        redir_isa   <= ret_isa;
      end else if (redir_ready) begin
        redir_valid <= 1'b0;
      end
    end
  end

  // R12: a stalled redirect holds
  p_redir_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_ready) |=>
      (redir_valid && $stable(redir_pc) && $stable(redir_isa)));
  // R10: clear pulse only right after a taken return, together with redirect
  p_ll_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ll_clear |-> (redir_valid && $past(eret_valid) && !$past(exc_valid)));
  // R11: exception wins over a simultaneous return
  p_exc_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && eret_valid && slot_free) |=> (!ll_clear && !redir_isa));
  // R10: redirected PC is halfword aligned on returns
  p_ret_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ll_clear |-> !redir_pc[0]);
endmodule

// File: tb/tb_trap_sequencer.sv
module tb_trap_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        cur_isa = 1'b0;
  logic        exc_valid = 1'b0;
  logic        exc_ready;
  logic [4:0]  exc_code = '0;
  logic        exc_in_slot = 1'b0;
  logic        eret_valid = 1'b0;
  logic        eret_ready;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_sel = '0;
  logic [31:0] ld_data = '0;
  logic        redir_valid;
  logic        redir_ready = 1'b1;
  logic [31:0] redir_pc;
  logic        redir_isa;
  logic        ll_clear;
  logic [31:0] status_q, cause_q, epc_q, errorepc_q, ebase_q;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  trap_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_isa(cur_isa),
    .exc_valid(exc_valid), .exc_ready(exc_ready), .exc_code(exc_code),
    .exc_in_slot(exc_in_slot), .eret_valid(eret_valid), .eret_ready(eret_ready),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .redir_valid(redir_valid), .redir_ready(redir_ready), .redir_pc(redir_pc),
    .redir_isa(redir_isa), .ll_clear(ll_clear), .status_q(status_q),
    .cause_q(cause_q), .epc_q(epc_q), .errorepc_q(errorepc_q), .ebase_q(ebase_q)
  );

  typedef struct packed {
    logic        bev;
    logic        exl;
    logic        erl;
    logic        iv;
    logic [4:0]  code;
    logic        slot;
    logic [31:0] pc;
    logic        isa;
    logic [31:0] vec;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 5'd8, 1'b0, 32'h0040_0010, 1'b0, 32'hBFC0_0380},
    '{1'b0, 1'b0, 1'b1, 1'b0, 5'd8, 1'b1, 32'h0040_0020, 1'b1, 32'h9000_0180},
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0, 32'h0040_0030, 1'b0, 32'h9000_0000},
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1, 32'h0040_0040, 1'b0, 32'h9000_0000},
    '{1'b1, 1'b0, 1'b0, 1'b0, 5'd2, 1'b0, 32'h0040_0050, 1'b1, 32'hBFC0_0200},
    '{1'b0, 1'b1, 1'b0, 1'b0, 5'd2, 1'b0, 32'h0040_0060, 1'b0, 32'h9000_0180},
    '{1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b1, 32'h0040_0070, 1'b0, 32'h9000_0200},
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 32'h0040_0080, 1'b0, 32'h9000_0180},
    '{1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 1'b1, 32'h0040_0090, 1'b0, 32'h9000_0180},
    '{1'b1, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 32'h0040_00A0, 1'b0, 32'hBFC0_0400}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] sel, input logic [31:0] data);
    ld_en = 1'b1; ld_sel = sel; ld_data = data;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_exc(input logic [4:0] code, input logic slot,
                        input logic [31:0] pc, input logic isa);
    exc_valid = 1'b1; exc_code = code; exc_in_slot = slot; cur_pc = pc; cur_isa = isa;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  task automatic do_ret();
    eret_valid = 1'b1;
    @(negedge clk);
    eret_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic exp_bd;
    logic [31:0] exp_epc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", status_q, 32'h0040_0000);
    check("R1 cause", cause_q, 32'h0);
    check("R1 ebase", ebase_q, 32'h8000_0000);
    check("R1 redir_valid", {31'b0, redir_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ll_clear", {31'b0, ll_clear}, 32'h0);

    // R6 base register low bits are not writable
    do_load(3'd4, 32'h9000_0ABC);
    check("R6 ebase mask", ebase_q, 32'h9000_0000);

    exp_bd = 1'b0;
    for (int i = 0; i < NV; i++) begin
      do_load(3'd2, 32'h1111_0000);
      do_load(3'd1, {8'h0, VT[i].iv, 23'h0});
      do_load(3'd0, {9'h0, VT[i].bev, 19'h0, VT[i].erl, VT[i].exl, 1'b0});
      do_exc(VT[i].code, VT[i].slot, VT[i].pc, VT[i].isa);
      exp_epc = VT[i].exl ? 32'h1111_0000 : (VT[i].pc | {31'b0, VT[i].isa});
      if (!VT[i].exl) exp_bd = VT[i].slot;
      check($sformatf("R6 R7 R8 vector %0d", i), redir_pc, VT[i].vec);
      check("R5 redir_valid", {31'b0, redir_valid}, 32'h1);
      check("R5 isa", {31'b0, redir_isa}, 32'h0);
      check("R2 R3 epc", epc_q, exp_epc);
      check("R2 R3 bd", {31'b0, cause_q[31]}, {31'b0, exp_bd});
      check("R4 code", {27'b0, cause_q[6:2]}, {27'b0, VT[i].code});
      check("R4 iv kept", {31'b0, cause_q[23]}, {31'b0, VT[i].iv});
      check("R5 exl erl", {30'b0, status_q[2:1]}, 32'h1);
      @(negedge clk);
    end

    // R9 R10 return from error level
    do_load(3'd3, 32'h00A0_0005);
    do_load(3'd0, 32'h0000_0006);
    do_ret();
    check("R9 err target", redir_pc, 32'h00A0_0004);
    check("R10 isa from bit0", {31'b0, redir_isa}, 32'h1);
    check("R10 ll_clear pulse", {31'b0, ll_clear}, 32'h1);
    check("R9 erl cleared exl kept", {30'b0, status_q[2:1]}, 32'h1);
    @(negedge clk);
    check("R10 ll_clear one cycle", {31'b0, ll_clear}, 32'h0);

    // R9 normal return
    do_load(3'd2, 32'h00B0_0008);
    do_ret();
    check("R9 epc target", redir_pc, 32'h00B0_0008);
    check("R10 isa 0", {31'b0, redir_isa}, 32'h0);
    check("R9 exl cleared", {30'b0, status_q[2:1]}, 32'h0);

    // R11 simultaneous exception and return
    @(negedge clk);
    eret_valid = 1'b1;
    do_exc(5'd8, 1'b0, 32'h0040_0100, 1'b0);
    eret_valid = 1'b0;
    check("R11 exception taken", redir_pc, 32'h9000_0180);
    check("R11 no ll_clear", {31'b0, ll_clear}, 32'h0);
    check("R11 exl set", {31'b0, status_q[1]}, 32'h1);

    // R13 load ignored during exception; cause only IV writable
    do_load(3'd0, 32'h0000_0000);
    ld_en = 1'b1; ld_sel = 3'd2; ld_data = 32'hDEAD_BEE0;
    do_exc(5'd9, 1'b0, 32'h0040_0200, 1'b0);
    ld_en = 1'b0;
    check("R13 load ignored", epc_q, 32'h0040_0200);
    do_load(3'd1, 32'hFFFF_FFFF);
    check("R13 cause iv only", cause_q, 32'h0080_0024);

    // R12 back-pressure
    do_load(3'd0, 32'h0000_0000);
    redir_ready = 1'b0;
    do_exc(5'd10, 1'b0, 32'h0040_0300, 1'b0);
    check("R12 valid", {31'b0, redir_valid}, 32'h1);
    check("R12 not ready", {30'b0, exc_ready, eret_ready}, 32'h0);
    do_exc(5'd2, 1'b0, 32'h0040_0400, 1'b0);
    check("R12 held pc", redir_pc, 32'h9000_0180);
    check("R12 request ignored", {27'b0, cause_q[6:2]}, 32'd10);
    check("R12 epc kept", epc_q, 32'h0040_0300);
    redir_ready = 1'b1;
    @(negedge clk);
    check("R12 drained", {31'b0, redir_valid}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule